// File: doc/BRIEF.md
# ADC Sample Buffer with Interrupt Merge

This block sits between an ADC conversion engine and a host register bus. Each converted sample that the engine presents with a valid strobe is stored in a first-in first-out buffer. The host drains the buffer through a data register, so conversions can run on their own and the host only needs to service the buffer now and then. A status register reports occupancy, empty, half-full and full.

Conversion starts come in from a pacing source as one-cycle requests. The block forwards each request to the ADC as a one-cycle go pulse. While the buffer is full it holds the go pulse back and remembers that a request came in. The first read that frees a slot releases that request, so no sample is ever dropped. Four interrupt sources are latched as sticky pending bits: buffer reached half-full, buffer reached full, end of conversion and end of scan. Each source has its own enable, and the interrupt line is the OR of the bits that are both pending and enabled.

Top module: `adc_sample_buffer`

## Requirements
- R1: A sample presented with `smp_valid` while the buffer is not full is stored. A register read at address 0 removes the oldest stored sample and presents it on `reg_rdata` in the cycle after the read, so samples come out in the order they arrived.
- R2: A read at address 1 returns the status word: bit 0 empty, bit 1 half-full (occupancy at least DEPTH/2), bit 2 full (occupancy equal to DEPTH), bits 4 and up the occupancy count. All other bits are 0.
- R3: A `conv_req` sampled while the buffer is not full produces a one-cycle `conv_go` in the next cycle.
- R4: A `conv_req` sampled while the buffer is full produces no `conv_go` and is remembered. `conv_go` is then raised on the clock edge after the edge that accepts the read which frees space.
- R5: The pending register at address 2 holds bit 0 (occupancy crossed up to at least DEPTH/2), bit 1 (occupancy reached DEPTH), bit 2 (`eoc_pulse`) and bit 3 (`eos_pulse`). The bits are sticky. Writing 1 to a bit at address 2 clears it, and a new event in the same cycle wins over the clear.
- R6: The enable register at address 3 (bits 3:0, same order as the pending bits) can be written and read back. `irq` equals the OR of pending AND enabled and changes on the same edge as the pending bits. A pending source that is not enabled does not raise `irq`.
- R7: A write to address 0 with bit 0 set empties the buffer and clears every pending bit.
- R8: After synchronous reset the buffer is empty, pending and enable are 0, and `irq`, `conv_go` and `reg_rdata` are 0.
- R9: A data read while the buffer is empty returns the last sample read and does not change the occupancy.
- R10: A sample strobe that arrives while the buffer is full is discarded, and the occupancy stays at DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Converted sample is valid this cycle |
| smp_data | input | DATA_W | Converted sample value |
| conv_req | input | 1 | Conversion-start request from the pacing source |
| conv_go | output | 1 | Conversion start issued to the ADC |
| eoc_pulse | input | 1 | End-of-conversion event |
| eos_pulse | input | 1 | End-of-scan event |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 data/clear, 1 status, 2 pending, 3 enable |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, valid the cycle after the read |
| irq | output | 1 | Merged interrupt request |

## Verification
The assertions check on every cycle that the occupancy never goes past DEPTH and that no go pulse follows a full cycle. They also check that pending bits survive every cycle without a clear, that `irq` is only raised while some bit is pending, and that a read of an empty buffer leaves the read data alone. What the assertions cannot show is left to the bench scenarios, which compare against a behavioural queue model: the order of the stored data, the exact release cycle of a held start after the buffer has been filled to its limit, the event that crosses half-full, the clear command, and the gating of a pending but disabled source.

// File: rtl/adc_buf_pkg.sv
package adc_buf_pkg;
  localparam int NSRC     = 4;
  localparam int SRC_HALF = 0;
  localparam int SRC_FULL = 1;
  localparam int SRC_EOC  = 2;
  localparam int SRC_EOS  = 3;

  typedef logic [NSRC-1:0] src_vec_t;

  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_STAT = 2'd1,
    REG_PEND = 2'd2,
    REG_EN   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic [DATA_W-1:0] din,
  input  logic              pop_req,
  output logic [DATA_W-1:0] dout,
  output logic [CW-1:0]     count,
  output logic              empty,
  output logic              half,
  output logic              full,
  output logic              half_evt,
  output logic              full_evt
);
  localparam int HALF = DEPTH / 2;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     cnt_nxt;
  logic              do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign half    = (count >= CW'(HALF));
  assign do_push = push & ~full & ~clr;
  assign do_pop  = pop_req & ~empty & ~clr;
  assign cnt_nxt = clr ? '0 : count + CW'(do_push) - CW'(do_pop);

  assign half_evt = (count < CW'(HALF)) && (cnt_nxt >= CW'(HALF));
  assign full_evt = !full && (cnt_nxt == CW'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)         dout <= '0;
    else if (do_pop) dout <= mem[rd_ptr];
  end
endmodule

// File: rtl/start_gate.sv
module start_gate (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic full,
  output logic go
);
  logic held;

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= 1'b0;
      go   <= 1'b0;
    end else if (full) begin
      go   <= 1'b0;
      held <= held | req;
    end else begin
      go   <= req | held;
      held <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_merge.sv
module irq_merge import adc_buf_pkg::*; (
  input  logic     clk,
  input  logic     rst,
  input  logic     clr,
  input  src_vec_t set,
  input  logic     w1c_we,
  input  src_vec_t w1c_mask,
  input  logic     en_we,
  input  src_vec_t en_d,
  output src_vec_t pend,
  output src_vec_t en,
  output logic     irq
);
  src_vec_t pend_nxt, en_nxt;

  always_comb begin
    en_nxt   = en_we ? en_d : en;
    pend_nxt = pend & ~(w1c_we ? w1c_mask : '0);
    pend_nxt = pend_nxt | set;
    if (clr) pend_nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      en   <= '0;
      irq  <= 1'b0;
    end else begin
      pend <= pend_nxt;
      en   <= en_nxt;
      irq  <= |(pend_nxt & en_nxt);
    end
  end
endmodule

// File: rtl/adc_sample_buffer.sv
module adc_sample_buffer import adc_buf_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic              conv_req,
  output logic              conv_go,
  input  logic              eoc_pulse,
  input  logic              eos_pulse,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] pop_data, csr_q, stat_word;
  logic [CNT_W-1:0]  fill_cnt;
  logic              f_empty, f_half, f_full, half_evt, full_evt;
  logic              fifo_clr, pop_req, w1c_we, en_we, sel_data_q;
  src_vec_t          src_set, pend, en;
  logic              wdata_unused;
  reg_sel_e          sel;

  assign sel          = reg_sel_e'(reg_addr);
  assign fifo_clr     = reg_wr && (sel == REG_DATA) && reg_wdata[0];
  assign pop_req      = reg_rd && (sel == REG_DATA);
  assign w1c_we       = reg_wr && (sel == REG_PEND);
  assign en_we        = reg_wr && (sel == REG_EN);
  assign wdata_unused = ^reg_wdata[DATA_W-1:NSRC];

  always_comb begin
    src_set           = '0;
    src_set[SRC_HALF] = half_evt;
    src_set[SRC_FULL] = full_evt;
    src_set[SRC_EOC]  = eoc_pulse;
    src_set[SRC_EOS]  = eos_pulse;
  end

  always_comb begin
    stat_word             = '0;
    stat_word[0]          = f_empty;
    stat_word[1]          = f_half;
    stat_word[2]          = f_full;
    stat_word[4 +: CNT_W] = fill_cnt;
  end

  sample_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .clr(fifo_clr),
    .push(smp_valid), .din(smp_data), .pop_req(pop_req), .dout(pop_data),
    .count(fill_cnt), .empty(f_empty), .half(f_half), .full(f_full),
    .half_evt(half_evt), .full_evt(full_evt)
  );

  start_gate u_gate (
    .clk(clk), .rst(rst), .req(conv_req), .full(f_full), .go(conv_go)
  );

  irq_merge u_irq (
    .clk(clk), .rst(rst), .clr(fifo_clr), .set(src_set),
    .w1c_we(w1c_we), .w1c_mask(reg_wdata[NSRC-1:0]),
    .en_we(en_we), .en_d(reg_wdata[NSRC-1:0]),
    .pend(pend), .en(en), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_data_q <= 1'b0;
      csr_q      <= '0;
    end else if (reg_rd) begin
      sel_data_q <= (sel == REG_DATA);
      case (sel)
        REG_STAT: csr_q <= stat_word;
        REG_PEND: csr_q <= DATA_W'(pend);
        REG_EN:   csr_q <= DATA_W'(en);
        default:  csr_q <= csr_q;
      endcase
    end
  end

  assign reg_rdata = sel_data_q ? pop_data : csr_q;
endmodule

// File: rtl/adc_sample_buffer_chk.sv
module adc_sample_buffer_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  parameter int NSRC   = 4,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [CW-1:0]     fill_cnt,
  input logic              f_full,
  input logic              f_empty,
  input logic              pop_req,
  input logic [DATA_W-1:0] pop_data,
  input logic              conv_go,
  input logic              irq,
  input logic [NSRC-1:0]   pend,
  input logic              w1c_we,
  input logic              fifo_clr
);
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    fill_cnt <= CW'(DEPTH));

  // R4
  no_go_when_full_chk: assert property (@(posedge clk) disable iff (rst)
    f_full |=> !conv_go);

  // R5
  sticky_pend_chk: assert property (@(posedge clk) disable iff (rst)
    !(w1c_we || fifo_clr) |=> ((pend & $past(pend)) == $past(pend)));

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (pend != '0));

  // R9
  empty_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (f_empty && pop_req) |=> $stable(pop_data));
endmodule

bind adc_sample_buffer adc_sample_buffer_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .NSRC(adc_buf_pkg::NSRC)
) u_chk (
  .clk(clk), .rst(rst), .fill_cnt(fill_cnt), .f_full(f_full),
  .f_empty(f_empty), .pop_req(pop_req), .pop_data(pop_data),
  .conv_go(conv_go), .irq(irq), .pend(pend), .w1c_we(w1c_we),
  .fifo_clr(fifo_clr)
);

// File: tb/adc_sample_buffer_test.sv
`timescale 1ns/1ps
module adc_sample_buffer_test;
  localparam int DW    = 16;
  localparam int DEPTH = 1024;
  localparam int HALF  = DEPTH / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 1'b0, conv_req = 1'b0, eoc_pulse = 1'b0, eos_pulse = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [DW-1:0] smp_data = '0, reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic conv_go, irq;

  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  adc_sample_buffer #(.DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .conv_req(conv_req), .conv_go(conv_go), .eoc_pulse(eoc_pulse),
    .eos_pulse(eos_pulse), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  task automatic check(input string tag, input string what,
                       input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] q[$];
  logic [3:0] m_pend, m_en, m_set;
  logic m_held, m_go, m_irq, m_sel, m_live;
  logic [DW-1:0] m_last, m_csr;
  string m_tag;
  int c0, c1;
  bit m_clr, m_full;

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_pend = '0; m_en = '0; m_held = 0; m_go = 0; m_irq = 0;
      m_sel = 0; m_last = '0; m_csr = '0; m_tag = "R8"; m_live = 1;
    end else begin
      c0 = q.size();
      m_full = (c0 == DEPTH);
      m_clr = reg_wr && reg_addr == 2'd0 && reg_wdata[0];
      if (reg_rd) begin
        case (reg_addr)
          2'd0: begin
            m_sel = 1; m_tag = (c0 == 0) ? "R9" : "R1";
            if (c0 != 0 && !m_clr) m_last = q[0];
          end
          2'd1: begin
            m_sel = 0; m_tag = "R2";
            m_csr = DW'(c0) << 4;
            m_csr[0] = (c0 == 0); m_csr[1] = (c0 >= HALF); m_csr[2] = m_full;
          end
          2'd2: begin m_sel = 0; m_tag = "R5"; m_csr = DW'(m_pend); end
          default: begin m_sel = 0; m_tag = "R6"; m_csr = DW'(m_en); end
        endcase
      end
      if (m_full) begin m_go = 0; m_held = m_held | conv_req; end
      else begin m_go = conv_req | m_held; m_held = 0; end
      m_set = {eos_pulse, eoc_pulse, 2'b00};
      if (m_clr) q.delete();
      else begin
        if (reg_rd && reg_addr == 2'd0 && c0 != 0) void'(q.pop_front());
        if (smp_valid && !m_full) q.push_back(smp_data);
        c1 = q.size();
        if (c0 < HALF && c1 >= HALF) m_set[0] = 1;
        if (c0 != DEPTH && c1 == DEPTH) m_set[1] = 1;
      end
      if (m_clr) m_pend = '0;
      else begin
        if (reg_wr && reg_addr == 2'd2) m_pend = m_pend & ~reg_wdata[3:0];
        m_pend = m_pend | m_set;
      end
      if (reg_wr && reg_addr == 2'd3) m_en = reg_wdata[3:0];
      m_irq = |(m_pend & m_en);
    end
  end

  always @(negedge clk) begin
    if (m_live && !done) begin
      check(m_tag, "reg_rdata", int'(reg_rdata), int'(m_sel ? m_last : m_csr));
      check("R3", "conv_go", int'(conv_go), int'(m_go));
      check("R6", "irq", int'(irq), int'(m_irq));
    end
  end

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] v);
    reg_rd = 1; reg_addr = a;
    @(negedge clk);
    reg_rd = 0;
    v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic push(input logic [DW-1:0] d);
    smp_valid = 1; smp_data = d;
    @(negedge clk);
    smp_valid = 0;
  endtask

  task automatic req_pulse();
    conv_req = 1;
    @(negedge clk);
    conv_req = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R8 reset state
    check("R8", "rdata after reset", int'(reg_rdata), 0);
    check("R8", "irq after reset", int'(irq), 0);
    check("R8", "conv_go after reset", int'(conv_go), 0);
    rd(2'd1, v); check("R8", "status after reset", int'(v), 1);
    rd(2'd2, v); check("R8", "pending after reset", int'(v), 0);

    // R6 enable readback
    wr(2'd3, 16'h000F);
    rd(2'd3, v); check("R6", "enable readback", int'(v), 15);

    // R3 start pass-through, R1 storage order
    for (int i = 0; i < 5; i++) begin
      req_pulse();
      check("R3", "go after request", int'(conv_go), 1);
      push(16'hA000 + 16'(i));
    end
    check("R3", "go single cycle", int'(conv_go), 0);

    // R5 end of conversion, sticky, write-one-to-clear
    eoc_pulse = 1; @(negedge clk); eoc_pulse = 0;
    check("R6", "irq on eoc", int'(irq), 1);
    repeat (2) @(negedge clk);
    rd(2'd2, v); check("R5", "eoc pending sticky", int'(v), 4);
    wr(2'd2, 16'h0004);
    rd(2'd2, v); check("R5", "eoc cleared", int'(v), 0);
    check("R6", "irq dropped", int'(irq), 0);

    // R5 set wins over clear in same cycle
    eos_pulse = 1; wr(2'd2, 16'h0008); eos_pulse = 0;
    rd(2'd2, v); check("R5", "eos set beats clear", int'(v), 8);
    wr(2'd2, 16'h000F);

    for (int i = 0; i < 5; i++) begin
      rd(2'd0, v); check("R1", "fifo order", int'(v), int'(16'hA000 + 16'(i)));
    end

    // R9 empty read
    rd(2'd0, v); check("R9", "empty read keeps last", int'(v), int'(16'hA004));
    rd(2'd1, v); check("R9", "empty read count", int'(v), 1);

    // fill to full
    for (int i = 0; i < DEPTH; i++) push(16'(i * 3));
    rd(2'd1, v); check("R2", "status full", int'(v), (DEPTH << 4) | 6);
    rd(2'd2, v); check("R5", "half and full pending", int'(v), 3);

    // R10 discard while full
    push(16'hFFFF);
    rd(2'd1, v); check("R10", "count held at depth", int'(v), (DEPTH << 4) | 6);

    // R4 back-pressure and release
    req_pulse();
    check("R4", "no go while full", int'(conv_go), 0);
    @(negedge clk);
    check("R4", "still held", int'(conv_go), 0);
    rd(2'd0, v);
    check("R1", "first of full set", int'(v), 0);
    check("R4", "go not yet", int'(conv_go), 0);
    @(negedge clk);
    check("R4", "held start released", int'(conv_go), 1);
    @(negedge clk);
    check("R4", "release single cycle", int'(conv_go), 0);
    rd(2'd0, v); check("R1", "second of full set", int'(v), 3);
    rd(2'd1, v); check("R2", "status after two reads", int'(v), ((DEPTH - 2) << 4) | 2);

    // R7 clear command
    wr(2'd0, 16'h0001);
    rd(2'd1, v); check("R7", "clear empties", int'(v), 1);
    rd(2'd2, v); check("R7", "clear drops pending", int'(v), 0);
    check("R7", "irq after clear", int'(irq), 0);

    // R6 disabled source gated
    wr(2'd3, 16'h0004);
    eos_pulse = 1; @(negedge clk); eos_pulse = 0;
    check("R6", "disabled source no irq", int'(irq), 0);
    rd(2'd2, v); check("R6", "disabled source pending", int'(v), 8);
    wr(2'd3, 16'h0008);
    check("R6", "enable raises irq", int'(irq), 1);

    // R2 half boundary
    wr(2'd0, 16'h0001);
    wr(2'd2, 16'h000F);
    for (int i = 0; i < HALF - 1; i++) push(16'(i));
    rd(2'd1, v); check("R2", "below half", int'(v), ((HALF - 1) << 4));
    push(16'h1234);
    rd(2'd1, v); check("R2", "at half", int'(v), (HALF << 4) | 2);
    rd(2'd2, v); check("R5", "half pending on crossing", int'(v), 1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule